// File: doc/BRIEF.md
# Source-Selected Clock Divider with Gated Prescaler

This block derives a processor subsystem clock from one of four incoming clocks. A 32-bit control word chooses the source and holds two division ratios. The first ratio is a prescaler that is placed in the path only when the high-speed source (select value 3) is chosen. The second ratio is a post divider that is always in the path. Software updates the word through a bit-masked write port, so it can change one field without touching the others, and reads the whole word back unchanged.

Each divider stage is a counter that runs in the domain of the clock it divides. A stage takes in a new ratio only at the terminal count of its current division cycle, after the value has crossed two synchronising flops and stayed the same across both. An output period therefore always has the old length or the new length and is never cut short. A ratio of 1 passes the stage's clock through unchanged. Other ratios give a high phase of floor(N/2) input periods out of N. The block also reports the combined division ratio as a plain output.

The select field is taken as static configuration. Changing it switches the source mux directly and does not get the glitch protection that ratio changes get.

Top module: `cpuclk_gen`

## Requirements
- R1: After reset the control word reads 0, the reported ratio is 1 and the output clock follows source 0 one for one.
- R2: A write changes exactly the control bits whose `wr_mask_i` bit is 1, setting them to `wr_data_i`. Every other bit keeps its value, including the select field.
- R3: Bits 17:16 choose the source: value k selects `src_clk_i[k]`.
- R4: Bits 12:8 hold a prescale ratio of field+1 (1 to 32). It applies only when the select is 3 and has no effect on the output for selects 0 to 2.
- R5: Bits 5:4 hold a post-divide ratio of field+1 (1 to 4). It applies for every select.
- R6: `total_ratio_o` equals (select==3 ? prescale+1 : 1) times (post+1). The output then shows exactly that many rising edges of the selected source per output period.
- R7: A total ratio of 1 passes the selected clock unchanged. Within a divider stage of ratio N>1, the output is high for floor(N/2) of the stage's input periods.
- R8: A ratio change never shortens a period. Each output period while a ratio is changing lasts the old or the new ratio, and once a period of the new ratio has been seen, no period of the old ratio follows.
- R9: Bits outside the three fields are stored and read back as written, and they reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk_i | input | 1 | Clock of the control register |
| rst_ni | input | 1 | Asynchronous active-low reset for all domains |
| src_clk_i | input | 4 | Candidate source clocks; bit 3 is the high-speed source |
| wr_en_i | input | 1 | Write strobe for the control register |
| wr_mask_i | input | 32 | Per-bit write enable |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current control word |
| clk_o | output | 1 | Divided output clock |
| total_ratio_o | output | 8 | Combined division ratio now configured |

## Verification
The bench counts rising edges of each source between output edges for every select with every post ratio. For select 3 it also uses prescale values 1, 2, 5 and 32. If the prescaler leaked into sources 0 to 2, the counts for those selects would come out five times too high. If the gating tested the wrong select value, source 3 would divide by the post ratio alone. A masked write of only the post field exposes a design that rewrites the whole word, because such a design would clear the select and unused bits. A post ratio changed in the middle of a division run exposes a stage that reloads immediately, because it would produce a period matching neither ratio. The high-time checks at ratios 1, 3 and 4 catch an off-by-one in the duty threshold.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned SEL_LSB  = 16;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned PRE_LSB  = 8;
  localparam int unsigned PRE_W    = 5;
  localparam int unsigned POST_LSB = 4;
  localparam int unsigned POST_W   = 2;
  localparam int unsigned PRE_SRC  = 3;
endpackage

// File: rtl/cpuclk_regs.sv
module cpuclk_regs #(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_mask_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] ctrl_o
);
  logic [REG_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= (ctrl_q & ~wr_mask_i) | (wr_data_i & wr_mask_i);
  end

  assign ctrl_o = ctrl_q;

  AST_MASK_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((ctrl_q & ~$past(wr_mask_i)) == ($past(ctrl_q) & ~$past(wr_mask_i)))); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctrl_q)); // R9
endmodule

// File: rtl/cpuclk_div_stage.sv
module cpuclk_div_stage #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ratio_m1_i,
  output logic         clk_o
);
  logic [W-1:0] sync1_q, sync2_q, cur_q, cnt_q;
  logic [W-1:0] cnt_nx, cur_nx;
  logic [W:0]   half;
  logic         term, q_q;

  always_comb begin
    term   = (cnt_q == cur_q);
    cnt_nx = term ? '0 : cnt_q + 1'b1;
    cur_nx = (term && (sync1_q == sync2_q)) ? sync2_q : cur_q;
    half   = ({1'b0, cur_nx} + 1'b1) >> 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
      cur_q   <= '0;
      cnt_q   <= '0;
      q_q     <= 1'b0;
    end else begin
      sync1_q <= ratio_m1_i;
      sync2_q <= sync1_q;
      cnt_q   <= cnt_nx;
      cur_q   <= cur_nx;
      q_q     <= ({1'b0, cnt_nx} < half);
    end
  end

  assign clk_o = (cur_q == '0) ? clk_i : q_q;

  AST_LOAD_AT_TERMINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_q) |-> ($past(cnt_q) == $past(cur_q))); // R8
  AST_COUNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= cur_q); // R8
endmodule

// File: rtl/cpuclk_gen.sv
module cpuclk_gen
  import cpuclk_pkg::*;
#(
  parameter int unsigned CTRL_W = REG_W,
  parameter int unsigned SW     = SEL_W,
  parameter int unsigned PW     = PRE_W,
  parameter int unsigned DW     = POST_W,
  parameter int unsigned RATIO_W = PRE_W + POST_W + 1
) (
  input  logic               cfg_clk_i,
  input  logic               rst_ni,
  input  logic [3:0]         src_clk_i,
  input  logic               wr_en_i,
  input  logic [CTRL_W-1:0]  wr_mask_i,
  input  logic [CTRL_W-1:0]  wr_data_i,
  output logic [CTRL_W-1:0]  rd_data_o,
  output logic               clk_o,
  output logic [RATIO_W-1:0] total_ratio_o
);
  localparam int unsigned MAX_RATIO = (1 << PW) * (1 << DW);

  logic [CTRL_W-1:0]  ctrl;
  logic [SW-1:0]      sel_f;
  logic [PW-1:0]      pre_f;
  logic [DW-1:0]      post_f;
  logic               pre_clk, mid_clk;
  logic [RATIO_W-1:0] pre_ratio, post_ratio;

  cpuclk_regs #(.REG_W(CTRL_W)) u_regs (
    .clk_i     (cfg_clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_mask_i (wr_mask_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl)
  );

  assign sel_f  = ctrl[SEL_LSB +: SW];
  assign pre_f  = ctrl[PRE_LSB +: PW];
  assign post_f = ctrl[POST_LSB +: DW];

  cpuclk_div_stage #(.W(PW)) u_pre (
    .clk_i      (src_clk_i[PRE_SRC]),
    .rst_ni     (rst_ni),
    .ratio_m1_i (pre_f),
    .clk_o      (pre_clk)
  );

  assign mid_clk = (sel_f == SW'(PRE_SRC)) ? pre_clk : src_clk_i[sel_f];

  cpuclk_div_stage #(.W(DW)) u_post (
    .clk_i      (mid_clk),
    .rst_ni     (rst_ni),
    .ratio_m1_i (post_f),
    .clk_o      (clk_o)
  );

  always_comb begin
    pre_ratio  = (sel_f == SW'(PRE_SRC)) ? RATIO_W'(pre_f) + 1'b1 : RATIO_W'(1);
    post_ratio = RATIO_W'(post_f) + 1'b1;
    total_ratio_o = pre_ratio * post_ratio;
  end

  assign rd_data_o = ctrl;

  AST_RATIO_BOUNDS: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    (total_ratio_o >= 1) && (32'(total_ratio_o) <= MAX_RATIO)); // R6
  AST_BYPASS_SMALL: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    (rd_data_o[SEL_LSB +: SW] != SW'(PRE_SRC)) |-> (32'(total_ratio_o) <= (1 << DW))); // R4
endmodule

// File: tb/cpuclk_gen_tb.sv
module cpuclk_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FIELDS = 32'h0003_1F30;

  logic cfg_clk = 0, rst_n = 0;
  logic s0 = 0, s1 = 0, s2 = 0, s3 = 0;
  logic wr_en = 0;
  logic [31:0] wr_mask = 0, wr_data = 0;
  logic [31:0] rd_data;
  logic clk_out;
  logic [7:0] ratio;
  int in_cnt [4];
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) cfg_clk = ~cfg_clk;
  always #5 s0 = ~s0;
  always #7 s1 = ~s1;
  always #6 s2 = ~s2;
  always #3 s3 = ~s3;

  initial for (int i = 0; i < 4; i++) in_cnt[i] = 0;
  always @(posedge s0) in_cnt[0] = in_cnt[0] + 1;
  always @(posedge s1) in_cnt[1] = in_cnt[1] + 1;
  always @(posedge s2) in_cnt[2] = in_cnt[2] + 1;
  always @(posedge s3) in_cnt[3] = in_cnt[3] + 1;

  cpuclk_gen u_dut (
    .cfg_clk_i(cfg_clk), .rst_ni(rst_n), .src_clk_i({s3, s2, s1, s0}),
    .wr_en_i(wr_en), .wr_mask_i(wr_mask), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .clk_o(clk_out), .total_ratio_o(ratio)
  );

  task automatic check(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic write_reg(logic [31:0] mask, logic [31:0] data);
    @(negedge cfg_clk);
    wr_en = 1; wr_mask = mask; wr_data = data;
    @(negedge cfg_clk);
    wr_en = 0;
    @(negedge cfg_clk);
  endtask

  task automatic wait_src(int s, int n);
    repeat (n) begin
      case (s)
        0: @(posedge s0);
        1: @(posedge s1);
        2: @(posedge s2);
        default: @(posedge s3);
      endcase
    end
  endtask

  function automatic int measure_prep(int s);
    return in_cnt[s];
  endfunction

  task automatic period(int s, output int n);
    int a;
    @(posedge clk_out); #1; a = in_cnt[s];
    @(posedge clk_out); #1; n = in_cnt[s] - a;
  endtask

  task automatic edges_over(int s, int k, output int n);
    int a;
    @(posedge clk_out); #1; a = measure_prep(s);
    repeat (k) @(posedge clk_out);
    #1; n = in_cnt[s] - a;
  endtask

  task automatic t_reset;
    int n;
    check("R1 control word", rd_data, 0);
    check("R1 ratio", ratio, 1);
    edges_over(0, 5, n);
    check("R1 follows source 0", n, 5);
  endtask

  task automatic t_masked_write;
    write_reg(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R9 all bits stored", rd_data, 32'hFFFF_FFFF);
    write_reg(32'h0000_0030, 32'h0000_0000);
    check("R2 only post field cleared", rd_data, 32'hFFFF_FFCF);
    write_reg(32'hFFFF_FFFF, 32'h0000_0000);
    write_reg(~FIELDS, 32'hA5A4_C0C5 & ~FIELDS);
    check("R9 unused bits readback", rd_data, 32'hA5A4_C0C5 & ~FIELDS);
    write_reg(FIELDS, 32'h0000_0020);
    check("R2 field write keeps unused bits", rd_data, (32'hA5A4_C0C5 & ~FIELDS) | 32'h20);
    write_reg(32'hFFFF_FFFF, 32'h0);
  endtask

  task automatic run_combo(int s, int pre, int post);
    int n, exp;
    write_reg(FIELDS, (32'(s) << 16) | (32'(pre) << 8) | (32'(post) << 4));
    exp = (s == 3) ? (pre + 1) * (post + 1) : (post + 1);
    check("R6 reported ratio", ratio, exp);
    wait_src(s, 300);
    edges_over(s, 3, n);
    if (s == 3) check("R4 R5 R6 prescaled source edges", n, 3 * exp);
    else        check("R3 R4 R5 bypassed source edges", n, 3 * exp);
  endtask

  task automatic t_sweep;
    int pres [4] = '{0, 1, 4, 31};
    for (int s = 0; s < 3; s++)
      for (int p = 0; p < 4; p++) run_combo(s, 4, p);
    for (int q = 0; q < 4; q++)
      for (int p = 0; p < 4; p++) run_combo(3, pres[q], p);
  endtask

  task automatic high_time(int post, int exp_ns);
    time t0, t1;
    write_reg(FIELDS, 32'(post) << 4);
    wait_src(0, 40);
    @(posedge clk_out); t0 = $time;
    @(negedge clk_out); t1 = $time;
    check("R7 high time", longint'(t1 - t0), exp_ns);
  endtask

  task automatic t_duty;
    high_time(0, 5);
    high_time(2, 10);
    high_time(3, 20);
  endtask

  task automatic t_switch;
    int n, bad, seen_new, back;
    write_reg(FIELDS, 32'h30);
    wait_src(0, 40);
    period(0, n);
    check("R8 old period", n, 4);
    @(negedge cfg_clk); wr_en = 1; wr_mask = FIELDS; wr_data = 32'h10;
    @(negedge cfg_clk); wr_en = 0;
    bad = 0; seen_new = 0; back = 0;
    for (int i = 0; i < 12; i++) begin
      period(0, n);
      if (n != 4 && n != 2) bad++;
      if (n == 2) seen_new = 1;
      if (n == 4 && seen_new) back++;
    end
    check("R8 no runt periods", bad, 0);
    check("R8 new ratio reached", seen_new, 1);
    check("R8 no return to old ratio", back, 0);
  endtask

  initial begin
    #(1_500_000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge cfg_clk);
    rst_n = 1;
    repeat (2) @(negedge cfg_clk);
    t_reset;
    t_masked_write;
    t_sweep;
    t_duty;
    t_switch;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule